// File: doc/BRIEF.md
# Hashed Page Table Walker

This block resolves a translation miss by walking a hashed page table held in ordinary memory. It receives the missing effective address, the 32-bit segment descriptor that covers it, the access kind (load, store or instruction fetch) and the privilege level. It forms a hash from the segment's virtual segment identifier and the page index, then probes one group of entries for that hash and, if nothing matches, a second group for the complemented hash. A matching entry's protection code is checked against the access, and its referenced and changed flags are updated in place with single-byte writes. The result is either a physical address with the granted rights, or a fault code.

All table traffic goes through one request/acknowledge memory port. The port carries 32-bit word reads and byte writes, and each transfer may take any number of cycles. The table base and the size mask are inputs taken when a request is accepted. One walk runs at a time, and `busy` is high while it runs.

Segment descriptor layout: bit 30 is the supervisor key, bit 29 the user key, bit 28 no-execute, and bits 23:0 the virtual segment identifier. Entry word 0, at byte offset 0, holds the valid flag in bit 31, the identifier in bits 30:7, the hash-select flag in bit 6 and the abbreviated page index in bits 5:0. Entry word 1, at byte offset 4, holds the real page number in bits 31:12, the referenced flag in bit 8, the changed flag in bit 7 and the protection code in bits 1:0. Memory is big-endian, so byte offset 6 is word-1 bits 15:8 and byte offset 7 is word-1 bits 7:0. The access kind is encoded as 0 for load, 1 for store and 2 for fetch.

Top module: `hpt_walker`

## Requirements
- R1: The page index is effective address bits 27:12. The hash is the identifier XOR the zero-extended page index. The first group address is `tbl_base | ((hash << 6) & tbl_mask)`, and entries sit at 8-byte steps inside the 64-byte group.
- R2: When no entry of the first group matches, the same eight slots are scanned in the group at `tbl_base | ((~hash << 6) & tbl_mask)`. An entry matches only if its hash-select flag equals the pass: 0 for the first group, 1 for the second.
- R3: An entry matches when it is valid and its bits 30:7 and 5:0 equal the identifier and page-index bits 15:10. Word 0 of an entry is always read before its word 1.
- R4: The protection key is the segment's user key when `req_user` is 1 and its supervisor key otherwise.
- R5: With key 0, codes 0, 1 and 2 give read and write, and code 3 gives read only. With key 1, code 0 gives nothing, codes 1 and 3 give read only, and code 2 gives read and write.
- R6: Execute is granted whenever the segment's no-execute bit is clear, independent of the key and the code. A fetch to a no-execute segment is a protection fault.
- R7: On a granted access to an entry whose referenced flag is clear, one byte write goes to entry offset 6 with word-1 bits 15:8 and bit 0 set. No referenced write happens when the flag is already set or the access faults.
- R8: A granted store to an entry whose changed flag is clear writes word-1 bits 7:0 with bit 7 set to entry offset 7. A load or fetch with the changed flag clear reports write permission as 0 and writes nothing.
- R9: A walk that finds no match faults with code 0x40000000 for a load or a fetch, and 0x42000000 for a store.
- R10: A protection failure faults with code 0x08000000 for a load or a fetch, and 0x0A000000 for a store. A successful walk reports code 0.
- R11: A successful walk returns the real page number joined with effective address bits 11:0.
- R12: A memory request keeps its address and direction until it is acknowledged. Each result is a one-cycle `resp_valid` pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a walk; taken when not busy |
| req_ea | input | 32 | Effective address that missed |
| req_seg | input | 32 | Segment descriptor for the address |
| req_kind | input | 2 | 0 load, 1 store, 2 fetch |
| req_user | input | 1 | 1 for user privilege |
| tbl_base | input | 32 | Table base address |
| tbl_mask | input | 32 | Group offset mask |
| busy | output | 1 | A walk is in progress |
| mem_req | output | 1 | Memory transfer pending |
| mem_we | output | 1 | 1 byte write, 0 word read |
| mem_addr | output | 32 | Byte address of the transfer |
| mem_wdata | output | 8 | Byte to write |
| mem_ack | input | 1 | Transfer finished this cycle |
| mem_rdata | input | 32 | Read word, valid with mem_ack |
| resp_valid | output | 1 | Result pulse |
| resp_fault | output | 1 | Result is a fault |
| resp_syndrome | output | 32 | Fault code, 0 on success |
| resp_pa | output | 32 | Physical address on success |
| resp_rd | output | 1 | Read granted |
| resp_wr | output | 1 | Write granted |
| resp_ex | output | 1 | Execute granted |

## Verification
The result appears on the clock edge after the acknowledge of the last memory transfer of a walk. That transfer is the word-1 read, a flag byte write, or the final tag read of a miss. Because memory latency varies, the time from request to result is not fixed. The bench therefore queues the expected result when it issues the request, and the monitor compares it on the falling edge where `resp_valid` is high. Byte writes and read order are logged as the memory model services them, and they are checked after each walk's result has been taken.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;
    localparam int ENTRY_BYTES  = 8;
    localparam int ENTRY_SHIFT  = 3;
    localparam int PAGE_BITS    = 12;
    localparam int VSID_W       = 24;
    localparam int PIDX_W       = 16;
    localparam int API_W        = 6;

    localparam int SEG_KEY_SUP  = 30;
    localparam int SEG_KEY_USR  = 29;
    localparam int SEG_NOEXEC   = 28;

    localparam int W0_VALID     = 31;
    localparam int W0_HSEL      = 6;
    localparam int W1_REF       = 8;
    localparam int W1_CHG       = 7;

    localparam logic [31:0] CODE_MISS_RD  = 32'h4000_0000;
    localparam logic [31:0] CODE_MISS_WR  = 32'h4200_0000;
    localparam logic [31:0] CODE_PROT_RD  = 32'h0800_0000;
    localparam logic [31:0] CODE_PROT_WR  = 32'h0A00_0000;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef struct packed {
        logic rd;
        logic wr;
        logic ex;
    } perm_t;

    function automatic perm_t pp_grant(input logic key, input logic [1:0] pp,
                                       input logic nx);
        perm_t g;
        g.ex = ~nx;
        if (!key) begin
            g.rd = 1'b1;
            g.wr = (pp != 2'd3);
        end else begin
            g.rd = (pp != 2'd0);
            g.wr = (pp == 2'd2);
        end
        return g;
    endfunction

    function automatic logic [31:0] fault_code(input acc_e kind, input logic miss);
        if (miss) return (kind == ACC_STORE) ? CODE_MISS_WR : CODE_MISS_RD;
        return (kind == ACC_STORE) ? CODE_PROT_WR : CODE_PROT_RD;
    endfunction
endpackage

// File: rtl/hpt_hash.sv
`timescale 1ns/1ps
module hpt_hash
    import hpt_pkg::*;
#(
    parameter int GROUP_SHIFT = 6
) (
    input  logic [VSID_W-1:0]       vsid,
    input  logic [PIDX_W-1:0]       pidx,
    input  logic [31:0]             tbl_base,
    input  logic [31:0]             tbl_mask,
    input  logic                    second,
    output logic [31:0]             grp_addr,
    output logic [VSID_W+API_W-1:0] cmp_key
);
    logic [31:0] hash;
    logic [31:0] hsel;

    always_comb begin
        hash     = {{(32-VSID_W){1'b0}}, vsid} ^ {{(32-PIDX_W){1'b0}}, pidx};
        hsel     = second ? ~hash : hash;
        grp_addr = tbl_base | ((hsel << GROUP_SHIFT) & tbl_mask);
        cmp_key  = {vsid, pidx[PIDX_W-1 -: API_W]};
    end
endmodule

// File: rtl/hpt_perm.sv
`timescale 1ns/1ps
module hpt_perm
    import hpt_pkg::*;
(
    input  logic       key_usr,
    input  logic       key_sup,
    input  logic       no_exec,
    input  logic       user,
    input  logic [1:0] pp,
    input  acc_e       kind,
    output perm_t      grant,
    output logic       deny
);
    always_comb begin
        grant = pp_grant(user ? key_usr : key_sup, pp, no_exec);
        unique case (kind)
            ACC_STORE: deny = ~grant.wr;
            ACC_FETCH: deny = ~grant.ex;
            default:   deny = ~grant.rd;
        endcase
    end
endmodule

// File: rtl/hpt_walker.sv
`timescale 1ns/1ps
module hpt_walker
    import hpt_pkg::*;
#(
    parameter int GROUP_ENTRIES = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    input  logic [31:0] req_ea,
    input  logic [31:0] req_seg,
    input  logic [1:0]  req_kind,
    input  logic        req_user,
    input  logic [31:0] tbl_base,
    input  logic [31:0] tbl_mask,
    output logic        busy,
    output logic        mem_req,
    output logic        mem_we,
    output logic [31:0] mem_addr,
    output logic [7:0]  mem_wdata,
    input  logic        mem_ack,
    input  logic [31:0] mem_rdata,
    output logic        resp_valid,
    output logic        resp_fault,
    output logic [31:0] resp_syndrome,
    output logic [31:0] resp_pa,
    output logic        resp_rd,
    output logic        resp_wr,
    output logic        resp_ex
);
    localparam int SLOT_W      = (GROUP_ENTRIES > 1) ? $clog2(GROUP_ENTRIES) : 1;
    localparam int GROUP_SHIFT = $clog2(GROUP_ENTRIES * ENTRY_BYTES);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(GROUP_ENTRIES - 1);

    typedef enum logic [2:0] {S_IDLE, S_TAG, S_DATA, S_SETR, S_SETC} st_e;

    st_e                     st;
    logic [VSID_W-1:0]       vsid_q;
    logic [PIDX_W-1:0]       pidx_q;
    logic [PAGE_BITS-1:0]    off_q;
    logic                    ks_q, ku_q, nx_q, user_q, pass_q;
    acc_e                    kind_q;
    logic [31:0]             base_q, mask_q, w1_q;
    logic [SLOT_W-1:0]       slot_q;
    perm_t                   perm_q, resp_perm, grant, grant_adj;
    logic                    deny, tag_hit;
    logic [31:0]             grp_addr, entry_addr;
    logic [VSID_W+API_W-1:0] cmp_key;

    hpt_hash #(.GROUP_SHIFT(GROUP_SHIFT)) u_hash (
        .vsid(vsid_q), .pidx(pidx_q), .tbl_base(base_q), .tbl_mask(mask_q),
        .second(pass_q), .grp_addr(grp_addr), .cmp_key(cmp_key)
    );

    hpt_perm u_perm (
        .key_usr(ku_q), .key_sup(ks_q), .no_exec(nx_q), .user(user_q),
        .pp(mem_rdata[1:0]), .kind(kind_q), .grant(grant), .deny(deny)
    );

    always_comb begin
        entry_addr = grp_addr + ({{(32-SLOT_W){1'b0}}, slot_q} << ENTRY_SHIFT);
        tag_hit    = mem_rdata[W0_VALID] && (mem_rdata[W0_HSEL] == pass_q) &&
                     ({mem_rdata[30:7], mem_rdata[5:0]} == cmp_key);
        grant_adj    = grant;
        grant_adj.wr = grant.wr & (mem_rdata[W1_CHG] | (kind_q == ACC_STORE));
        busy       = (st != S_IDLE);
        mem_req    = (st != S_IDLE);
        mem_we     = (st == S_SETR) || (st == S_SETC);
        unique case (st)
            S_DATA:  begin mem_addr = entry_addr + 32'd4; mem_wdata = 8'h00; end
            S_SETR:  begin mem_addr = entry_addr + 32'd6; mem_wdata = w1_q[15:8] | 8'h01; end
            S_SETC:  begin mem_addr = entry_addr + 32'd7; mem_wdata = w1_q[7:0]  | 8'h80; end
            default: begin mem_addr = entry_addr;         mem_wdata = 8'h00; end
        endcase
        resp_rd = resp_perm.rd;
        resp_wr = resp_perm.wr;
        resp_ex = resp_perm.ex;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st            <= S_IDLE;
            resp_valid    <= 1'b0;
            resp_fault    <= 1'b0;
            resp_syndrome <= '0;
            resp_pa       <= '0;
            resp_perm     <= '0;
            vsid_q <= '0; pidx_q <= '0; off_q <= '0;
            ks_q <= 1'b0; ku_q <= 1'b0; nx_q <= 1'b0; user_q <= 1'b0;
            kind_q <= ACC_LOAD; base_q <= '0; mask_q <= '0;
            pass_q <= 1'b0; slot_q <= '0; w1_q <= '0; perm_q <= '0;
        end else begin
            resp_valid <= 1'b0;
            unique case (st)
                S_IDLE: if (req_valid) begin
                    vsid_q <= req_seg[VSID_W-1:0];
                    ks_q   <= req_seg[SEG_KEY_SUP];
                    ku_q   <= req_seg[SEG_KEY_USR];
                    nx_q   <= req_seg[SEG_NOEXEC];
                    pidx_q <= req_ea[PAGE_BITS+PIDX_W-1:PAGE_BITS];
                    off_q  <= req_ea[PAGE_BITS-1:0];
                    kind_q <= acc_e'(req_kind);
                    user_q <= req_user;
                    base_q <= tbl_base;
                    mask_q <= tbl_mask;
                    pass_q <= 1'b0;
                    slot_q <= '0;
                    st     <= S_TAG;
                end
                S_TAG: if (mem_ack) begin
                    if (tag_hit) begin
                        st <= S_DATA;
                    end else if (slot_q != LAST_SLOT) begin
                        slot_q <= slot_q + 1'b1;
                    end else if (!pass_q) begin
                        pass_q <= 1'b1;
                        slot_q <= '0;
                    end else begin
                        resp_valid    <= 1'b1;
                        resp_fault    <= 1'b1;
                        resp_syndrome <= fault_code(kind_q, 1'b1);
                        resp_pa       <= '0;
                        resp_perm     <= '0;
                        st            <= S_IDLE;
                    end
                end
                S_DATA: if (mem_ack) begin
                    w1_q   <= mem_rdata;
                    perm_q <= grant_adj;
                    if (deny) begin
                        resp_valid    <= 1'b1;
                        resp_fault    <= 1'b1;
                        resp_syndrome <= fault_code(kind_q, 1'b0);
                        resp_pa       <= '0;
                        resp_perm     <= '0;
                        st            <= S_IDLE;
                    end else if (!mem_rdata[W1_REF]) begin
                        st <= S_SETR;
                    end else if (!mem_rdata[W1_CHG] && kind_q == ACC_STORE) begin
                        st <= S_SETC;
                    end else begin
                        resp_valid    <= 1'b1;
                        resp_fault    <= 1'b0;
                        resp_syndrome <= '0;
                        resp_pa       <= {mem_rdata[31:PAGE_BITS], off_q};
                        resp_perm     <= grant_adj;
                        st            <= S_IDLE;
                    end
                end
                S_SETR: if (mem_ack) begin
                    if (!w1_q[W1_CHG] && kind_q == ACC_STORE) begin
                        st <= S_SETC;
                    end else begin
                        resp_valid    <= 1'b1;
                        resp_fault    <= 1'b0;
                        resp_syndrome <= '0;
                        resp_pa       <= {w1_q[31:PAGE_BITS], off_q};
                        resp_perm     <= perm_q;
                        st            <= S_IDLE;
                    end
                end
                S_SETC: if (mem_ack) begin
                    resp_valid    <= 1'b1;
                    resp_fault    <= 1'b0;
                    resp_syndrome <= '0;
                    resp_pa       <= {w1_q[31:PAGE_BITS], off_q};
                    resp_perm     <= perm_q;
                    st            <= S_IDLE;
                end
                default: st <= S_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hpt_walker_chk.sv
`timescale 1ns/1ps
module hpt_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        mem_req,
    input logic        mem_we,
    input logic [31:0] mem_addr,
    input logic [7:0]  mem_wdata,
    input logic        mem_ack,
    input logic        resp_valid,
    input logic        resp_fault,
    input logic [31:0] resp_syndrome
);
    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we)); // R12

    AST_RESP_PULSE: assert property (@(posedge clk) disable iff (rst)
        resp_valid |=> !resp_valid); // R12

    AST_REF_BYTE: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_addr[2:0] == 3'd6 |-> mem_wdata[0]); // R7

    AST_CHG_BYTE: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we && mem_addr[2:0] == 3'd7 |-> mem_wdata[7]); // R8

    AST_WRITE_OFFSET: assert property (@(posedge clk) disable iff (rst)
        mem_req && mem_we |-> mem_addr[2:1] == 2'b11); // R7

    AST_READ_ALIGN: assert property (@(posedge clk) disable iff (rst)
        mem_req && !mem_we |-> mem_addr[1:0] == 2'b00); // R3

    AST_FAULT_CODE: assert property (@(posedge clk) disable iff (rst)
        resp_valid && resp_fault |-> (resp_syndrome == 32'h4000_0000 ||
            resp_syndrome == 32'h4200_0000 || resp_syndrome == 32'h0800_0000 ||
            resp_syndrome == 32'h0A00_0000)); // R9

    AST_OK_CODE: assert property (@(posedge clk) disable iff (rst)
        resp_valid && !resp_fault |-> resp_syndrome == 32'h0); // R10
endmodule

bind hpt_walker hpt_walker_chk u_chk (.*);

// File: tb/hpt_walker_tb.sv
`timescale 1ns/1ps
module hpt_walker_tb;
    localparam logic [31:0] BASE = 32'h0001_0000;
    localparam logic [31:0] MASK = 32'h0000_0FC0;
    localparam logic [1:0] LD = 2'd0, ST = 2'd1, FE = 2'd2;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst, req_valid, req_user, busy, mem_req, mem_we, mem_ack;
    logic [31:0] req_ea, req_seg, mem_addr, mem_rdata, resp_syndrome, resp_pa;
    logic [1:0]  req_kind;
    logic [7:0]  mem_wdata;
    logic        resp_valid, resp_fault, resp_rd, resp_wr, resp_ex;

    hpt_walker u_dut (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ea(req_ea),
        .req_seg(req_seg), .req_kind(req_kind), .req_user(req_user),
        .tbl_base(BASE), .tbl_mask(MASK), .busy(busy), .mem_req(mem_req),
        .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_ack(mem_ack), .mem_rdata(mem_rdata), .resp_valid(resp_valid),
        .resp_fault(resp_fault), .resp_syndrome(resp_syndrome), .resp_pa(resp_pa),
        .resp_rd(resp_rd), .resp_wr(resp_wr), .resp_ex(resp_ex)
    );

    typedef struct {
        logic        fault;
        logic [31:0] code;
        logic [31:0] pa;
        logic [2:0]  perm;
        string       tag;
    } exp_t;

    exp_t        sb[$];
    int          n_chk = 0, n_bad = 0;
    logic [31:0] mem [0:1023];
    int          wr6_cnt, wr7_cnt, order_bad = 0;
    logic [7:0]  wr6_val, wr7_val;
    logic [31:0] first_rd, prev_rd;
    logic        first_seen;
    int          lat = 0, lat_seq = 0;
    bit          finished = 1'b0;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    // memory model: variable latency, services at the falling edge
    initial begin
        mem_ack = 1'b0; mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) mem_ack = 1'b0;
            else if (mem_req && !rst) begin
                if (lat == 0) begin
                    automatic int idx = int'((mem_addr - BASE) >> 2) & 1023;
                    if (mem_we) begin
                        automatic int sh = (3 - int'(mem_addr[1:0])) * 8;
                        mem[idx] = (mem[idx] & ~(32'hFF << sh)) | ({24'h0, mem_wdata} << sh);
                        if (mem_addr[2:0] == 3'd6) begin wr6_cnt++; wr6_val = mem_wdata; end
                        if (mem_addr[2:0] == 3'd7) begin wr7_cnt++; wr7_val = mem_wdata; end
                    end else begin
                        mem_rdata = mem[idx];
                        if (!first_seen) begin first_rd = mem_addr; first_seen = 1'b1; end
                        if (mem_addr[2] && prev_rd != mem_addr - 32'd4) order_bad++;
                        prev_rd = mem_addr;
                    end
                    mem_ack = 1'b1;
                    lat_seq++;
                    lat = (lat_seq * 7) % 4;
                end else lat--;
            end
        end
    end

    // monitor: pops the scoreboard when a result shows up
    always @(negedge clk) begin
        if (!rst && resp_valid) begin
            if (sb.size() == 0) check(1'b0, "R12 unexpected result", 32'h1, 32'h0);
            else begin
                automatic exp_t e = sb.pop_front();
                check(resp_fault == e.fault, {e.tag, " fault"}, {31'h0, resp_fault}, {31'h0, e.fault});
                check(resp_syndrome == e.code, {e.tag, " code"}, resp_syndrome, e.code);
                if (!e.fault) begin
                    check(resp_pa == e.pa, {e.tag, " pa"}, resp_pa, e.pa);
                    check({resp_rd, resp_wr, resp_ex} == e.perm, {e.tag, " perm"},
                          {29'h0, resp_rd, resp_wr, resp_ex}, {29'h0, e.perm});
                end
            end
        end
    end

    function automatic logic [31:0] hsh(input logic [23:0] vsid, input logic [31:0] ea);
        return {8'h0, vsid} ^ {16'h0, ea[27:12]};
    endfunction
    function automatic logic [31:0] grp(input logic [23:0] vsid, input logic [31:0] ea,
                                        input bit second);
        logic [31:0] h = hsh(vsid, ea);
        if (second) h = ~h;
        return BASE | ((h << 6) & MASK);
    endfunction
    function automatic logic [31:0] seg(input bit ks, input bit ku, input bit nx,
                                        input logic [23:0] vsid);
        return {1'b0, ks, ku, nx, 4'h0, vsid};
    endfunction
    function automatic logic [31:0] w0(input logic [23:0] vsid, input logic [5:0] api,
                                       input bit hs);
        return {1'b1, vsid, hs, api};
    endfunction
    function automatic logic [31:0] w1(input logic [19:0] rpn, input bit r, input bit c,
                                       input logic [1:0] pp);
        return {rpn, 3'b0, r, c, 5'b0, pp};
    endfunction

    task automatic put(input logic [31:0] addr, input logic [31:0] a, input logic [31:0] b);
        mem[int'((addr - BASE) >> 2)]     = a;
        mem[int'((addr - BASE) >> 2) + 1] = b;
    endtask
    task automatic clear_mem();
        for (int i = 0; i < 1024; i++) mem[i] = '0;
    endtask

    task automatic run(input logic [1:0] kind, input bit user, input logic [31:0] ea,
                       input logic [31:0] sg, input bit f, input logic [31:0] code,
                       input logic [31:0] pa, input logic [2:0] perm, input string tag);
        exp_t e;
        e.fault = f; e.code = code; e.pa = pa; e.perm = perm; e.tag = tag;
        sb.push_back(e);
        wr6_cnt = 0; wr7_cnt = 0; first_seen = 1'b0;
        @(negedge clk);
        req_kind = kind; req_user = user; req_ea = ea; req_seg = sg; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        wait (sb.size() == 0);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            check(1'b0, "watchdog", 32'h0, 32'h1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        logic [23:0] v;
        logic [31:0] ea, a;
        rst = 1'b1; req_valid = 1'b0; req_ea = '0; req_seg = '0; req_kind = '0; req_user = 1'b0;
        clear_mem();
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(!resp_valid && !mem_req && !busy, "R12 reset state",
              {29'h0, resp_valid, mem_req, busy}, 32'h0);
        rst = 1'b0;

        // primary hit, load, R and C clear
        v = 24'h123456; ea = 32'h3ABC_5345;
        a = grp(v, ea, 1'b0);
        put(a, w0(v, ea[27:22], 1'b0), w1(20'hABCDE, 1'b0, 1'b0, 2'd2));
        run(LD, 1'b0, ea, seg(0, 1, 0, v), 0, 0, 32'hABCD_E345, 3'b101, "R8 R11 load C clear");
        check(first_rd == a, "R1 first group address", first_rd, a);
        check(wr6_cnt == 1 && wr6_val == 8'hE1, "R7 referenced byte", {24'h0, wr6_val}, 32'hE1);
        check(wr7_cnt == 0, "R8 no changed write on load", wr7_cnt, 0);
        // same entry, store: R now set, C gets written
        run(ST, 1'b0, ea, seg(0, 1, 0, v), 0, 0, 32'hABCD_E345, 3'b111, "R8 store");
        check(wr6_cnt == 0, "R7 no rewrite when set", wr6_cnt, 0);
        check(wr7_cnt == 1 && wr7_val == 8'h82, "R8 changed byte", {24'h0, wr7_val}, 32'h82);

        // secondary hit behind primary decoys
        clear_mem();
        v = 24'h00F0F0; ea = 32'h1234_5678;
        for (int s = 0; s < 8; s++)
            put(grp(v, ea, 1'b0) + 32'(s * 8), w0(v, ea[27:22], 1'b1), w1(20'h11111, 1, 1, 2'd2));
        put(grp(v, ea, 1'b1), w0(v, ea[27:22] + 6'd1, 1'b1), w1(20'h22222, 1, 1, 2'd2));
        put(grp(v, ea, 1'b1) + 32'd40, w0(v, ea[27:22], 1'b1), w1(20'h13579, 1, 1, 2'd0));
        run(ST, 1'b0, ea, seg(0, 0, 0, v), 0, 0, 32'h1357_9678, 3'b111, "R2 R3 secondary hit");
        check(wr6_cnt == 0 && wr7_cnt == 0, "R7 no writes with R C set", wr6_cnt + wr7_cnt, 0);
        check(order_bad == 0, "R3 word order", order_bad, 0);

        // misses
        clear_mem();
        run(LD, 1'b0, ea, seg(0, 0, 0, v), 1, 32'h4000_0000, 0, 0, "R9 load miss");
        run(ST, 1'b0, ea, seg(0, 0, 0, v), 1, 32'h4200_0000, 0, 0, "R9 store miss");
        run(FE, 1'b0, ea, seg(0, 0, 0, v), 1, 32'h4000_0000, 0, 0, "R9 fetch miss");

        // key selection and protection table
        v = 24'h0A0A0A; ea = 32'h0000_2010; a = grp(v, ea, 1'b0) + 32'd8;
        put(a, w0(v, ea[27:22], 1'b0), w1(20'h00777, 1, 1, 2'd0));
        run(LD, 1'b1, ea, seg(0, 1, 0, v), 1, 32'h0800_0000, 0, 0, "R4 R10 user key1 pp0 load");
        check(wr6_cnt == 0, "R7 no write on fault", wr6_cnt, 0);
        run(LD, 1'b0, ea, seg(0, 1, 0, v), 0, 0, 32'h0077_7010, 3'b111, "R4 R5 supervisor key0 pp0");
        put(a, w0(v, ea[27:22], 1'b0), w1(20'h00777, 1, 1, 2'd1));
        run(ST, 1'b1, ea, seg(0, 1, 0, v), 1, 32'h0A00_0000, 0, 0, "R5 R10 key1 pp1 store");
        run(LD, 1'b1, ea, seg(0, 1, 0, v), 0, 0, 32'h0077_7010, 3'b101, "R5 key1 pp1 load");
        put(a, w0(v, ea[27:22], 1'b0), w1(20'h00777, 1, 1, 2'd2));
        run(ST, 1'b1, ea, seg(0, 1, 0, v), 0, 0, 32'h0077_7010, 3'b111, "R5 key1 pp2 store");
        put(a, w0(v, ea[27:22], 1'b0), w1(20'h00777, 1, 1, 2'd3));
        run(ST, 1'b1, ea, seg(0, 1, 0, v), 1, 32'h0A00_0000, 0, 0, "R5 key1 pp3 store");
        run(ST, 1'b0, ea, seg(0, 1, 0, v), 1, 32'h0A00_0000, 0, 0, "R5 key0 pp3 store");
        run(LD, 1'b0, ea, seg(0, 1, 0, v), 0, 0, 32'h0077_7010, 3'b101, "R5 key0 pp3 load");

        // execute control
        put(a, w0(v, ea[27:22], 1'b0), w1(20'h00777, 1, 1, 2'd2));
        run(FE, 1'b0, ea, seg(0, 0, 1, v), 1, 32'h0800_0000, 0, 0, "R6 fetch no-exec");
        put(a, w0(v, ea[27:22], 1'b0), w1(20'h00777, 1, 1, 2'd0));
        run(FE, 1'b1, ea, seg(0, 1, 0, v), 0, 0, 32'h0077_7010, 3'b001, "R6 fetch key1 pp0");

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule